// File: doc/BRIEF.md
# ADC Group Start Trigger Controller

This block decides when a multi-channel analog-to-digital converter begins a group of conversions. Three request sources can start a group. The first is a software write to a start bit. The second is an active-low trigger from outside the chip. The third is an active-low trigger from an on-chip event. Each hardware source has its own enable. Each hardware input passes through a two-flop synchroniser and then a minimum low-width filter before it counts as a trigger.

A single start/busy flag records whether a group is running. When a trigger is accepted, the flag sets and a one-cycle start pulse goes to the conversion sequencer. In single-group mode, the end-of-group pulse from the sequencer clears the flag. In continuous mode the flag stays set, so later triggers have no effect until software writes 0 to the start bit.

The block also holds the converter's power-enable bit. This bit is clear after reset, software can write it, and a halt request clears it. The external trigger works regardless of this bit. The on-chip trigger and the software start need power to be on.

Top module: `adc_trig_ctrl`

## Requirements
- R1: After synchronous reset, `busy`, `start_pulse` and `pwr_on` are all 0.
- R2: A hardware trigger counts only after its synchronised level has been low for two consecutive cycles. Suppose the input goes low just after a rising edge and stays low for at least two cycles. Then `busy` and `start_pulse` are 1 after the fourth rising edge. A low lasting only one cycle is discarded.
- R3: A hardware trigger is accepted at most once per low period. An input held low does not start a new group after the previous one ends.
- R4: A hardware source whose enable (`ext_en` or `onchip_en`) is 0 never sets `busy`.
- R5: `start_pulse` is high for exactly one cycle, and that is the same cycle in which `busy` rises.
- R6: In single mode (`mode_cont`=0), when `grp_done` arrives while busy, `busy` is 0 after the next edge.
- R7: In continuous mode (`mode_cont`=1), `grp_done` does not clear `busy`, and no trigger produces a further `start_pulse`.
- R8: Any trigger that arrives while `busy` is 1 is ignored and produces no `start_pulse`, in either mode.
- R9: The external trigger sets `busy` even when `pwr_on` is 0. The on-chip trigger and the software start have no effect while `pwr_on` is 0.
- R10: When `sw_wr` is asserted with `sw_start`=1 while idle and powered, `busy` is set at the next edge with no width check. When `sw_wr` is asserted with `sw_start`=0, `busy` is cleared at the next edge in either mode.
- R11: `pwr_on` takes the value of `pwr_set` when `pwr_wr` is 1. If `halt_req` is 1, `pwr_on` is 0 after the next edge, and this takes priority over a simultaneous write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cont | input | 1 | 0 = single group, 1 = continuous |
| ext_en | input | 1 | Enable for the external trigger |
| onchip_en | input | 1 | Enable for the on-chip trigger |
| sw_wr | input | 1 | Software write strobe for the start bit |
| sw_start | input | 1 | Value written to the start bit |
| pwr_wr | input | 1 | Software write strobe for the power bit |
| pwr_set | input | 1 | Value written to the power bit |
| halt_req | input | 1 | Halt request; clears the power bit |
| ext_trig_n | input | 1 | External trigger, active low, asynchronous |
| onchip_trig_n | input | 1 | On-chip event trigger, active low, asynchronous |
| grp_done | input | 1 | End-of-group pulse from the sequencer |
| start_pulse | output | 1 | One-cycle group start to the sequencer |
| busy | output | 1 | Start/busy flag |
| pwr_on | output | 1 | Power-enable bit |

## Verification
The bench targets several corner cases, and each one exposes a specific class of bug:
- A one-cycle low glitch would start a group in a design without a width filter.
- A trigger held low past the end of a group would restart conversion in a design that re-accepts levels rather than edges.
- Triggers during a running group, including in continuous mode, would cause spurious start pulses if the busy gate were missing.
- An external trigger with power off checks that the power gate covers only the on-chip and software sources; a design that applied it to the external trigger too would stay idle.
- A halt request that coincides with a power write shows whether halt has priority.

Long random runs against a cycle model in the bench exercise enables, mode changes and overlapping done and stop events.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

    localparam int unsigned SRC_N      = 2;
    localparam int unsigned SRC_EXT    = 0;
    localparam int unsigned SRC_ONCHIP = 1;

    // Sources that are blocked while the converter is unpowered
    localparam logic [SRC_N-1:0] SRC_NEEDS_PWR = 2'b10;

    typedef enum logic {
        GRP_SINGLE = 1'b0,
        GRP_CONT   = 1'b1
    } grp_mode_t;

    typedef struct packed {
        logic wr;
        logic val;
    } sw_cmd_t;

    function automatic logic src_gate(input logic acc, input logic en,
                                      input logic pwr, input logic needs_pwr);
        return acc & en & (pwr | ~needs_pwr);
    endfunction

endpackage

// File: rtl/trig_qual.sv
module trig_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic trig_n,
    output logic acc
);
    localparam int unsigned CNT_W = $clog2(MIN_LOW + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic [CNT_W-1:0]       low_cnt;
    logic                   lvl;

    assign lvl = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], trig_n};
        end
    end

    always_ff @(posedge clk) begin
        if (rst || lvl) begin
            low_cnt <= '0;
        end else if (low_cnt != CNT_W'(MIN_LOW)) begin
            low_cnt <= low_cnt + 1'b1;
        end
    end

    assign acc = ~lvl && (low_cnt == CNT_W'(MIN_LOW - 1));

    // R2
    acc_low_hist_chk: assert property (@(posedge clk) disable iff (rst)
        acc |-> (!lvl && !$past(lvl)));

    // R3
    acc_once_chk: assert property (@(posedge clk) disable iff (rst)
        acc |=> !acc);

endmodule

// File: rtl/start_ctrl.sv
module start_ctrl
    import adc_trig_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [SRC_N-1:0] hw_acc,
    input  logic [SRC_N-1:0] hw_en,
    input  logic             pwr_on,
    input  grp_mode_t        mode,
    input  sw_cmd_t          sw,
    input  logic             grp_done,
    output logic             busy,
    output logic             start_pulse
);
    logic [SRC_N-1:0] gated;
    logic sw_go, sw_stop, trig_any, go;

    for (genvar i = 0; i < SRC_N; i++) begin : g_gate
        assign gated[i] = src_gate(hw_acc[i], hw_en[i], pwr_on, SRC_NEEDS_PWR[i]);
    end

    assign sw_go    = sw.wr & sw.val & pwr_on;
    assign sw_stop  = sw.wr & ~sw.val;
    assign trig_any = (|gated) | sw_go;
    assign go       = ~busy & trig_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy        <= 1'b0;
            start_pulse <= 1'b0;
        end else begin
            start_pulse <= go;
            if (go) begin
                busy <= 1'b1;
            end else if (busy && ((grp_done && mode == GRP_SINGLE) || sw_stop)) begin
                busy <= 1'b0;
            end
        end
    end

    // R5
    pulse_on_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> start_pulse);

    // R5
    pulse_width_chk: assert property (@(posedge clk) disable iff (rst)
        start_pulse |=> !start_pulse);

    // R6
    single_done_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && grp_done && mode == GRP_SINGLE) |=> !busy);

    // R7
    cont_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && mode == GRP_CONT && !(sw.wr && !sw.val)) |=> busy);

    // R8
    busy_no_restart_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> !start_pulse);

endmodule

// File: rtl/pwr_ctrl.sv
module pwr_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic wr,
    input  logic val,
    input  logic halt_req,
    output logic pwr_on
);
    always_ff @(posedge clk) begin
        if (rst || halt_req) begin
            pwr_on <= 1'b0;
        end else if (wr) begin
            pwr_on <= val;
        end
    end

    // R11
    halt_clears_chk: assert property (@(posedge clk) disable iff (rst)
        halt_req |=> !pwr_on);

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
    import adc_trig_pkg::*;
#(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_LOW     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic mode_cont,
    input  logic ext_en,
    input  logic onchip_en,
    input  logic sw_wr,
    input  logic sw_start,
    input  logic pwr_wr,
    input  logic pwr_set,
    input  logic halt_req,
    input  logic ext_trig_n,
    input  logic onchip_trig_n,
    input  logic grp_done,
    output logic start_pulse,
    output logic busy,
    output logic pwr_on
);
    logic [SRC_N-1:0] raw_n, acc, en;
    sw_cmd_t          sw;

    assign raw_n[SRC_EXT]    = ext_trig_n;
    assign raw_n[SRC_ONCHIP] = onchip_trig_n;
    assign en[SRC_EXT]       = ext_en;
    assign en[SRC_ONCHIP]    = onchip_en;
    assign sw.wr             = sw_wr;
    assign sw.val            = sw_start;

    for (genvar i = 0; i < SRC_N; i++) begin : g_src
        trig_qual #(
            .SYNC_STAGES (SYNC_STAGES),
            .MIN_LOW     (MIN_LOW)
        ) u_qual (
            .clk    (clk),
            .rst    (rst),
            .trig_n (raw_n[i]),
            .acc    (acc[i])
        );
    end

    pwr_ctrl u_pwr (
        .clk      (clk),
        .rst      (rst),
        .wr       (pwr_wr),
        .val      (pwr_set),
        .halt_req (halt_req),
        .pwr_on   (pwr_on)
    );

    start_ctrl u_start (
        .clk         (clk),
        .rst         (rst),
        .hw_acc      (acc),
        .hw_en       (en),
        .pwr_on      (pwr_on),
        .mode        (grp_mode_t'(mode_cont)),
        .sw          (sw),
        .grp_done    (grp_done),
        .busy        (busy),
        .start_pulse (start_pulse)
    );

    // R1
    reset_state_chk: assert property (@(posedge clk)
        $past(rst) |-> (!busy && !start_pulse && !pwr_on));

endmodule

// File: tb/adc_trig_ctrl_tb.sv
module adc_trig_ctrl_tb;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic mode_cont = 0, ext_en = 0, onchip_en = 0, sw_wr = 0, sw_start = 0;
    logic pwr_wr = 0, pwr_set = 0, halt_req = 0, grp_done = 0;
    logic ext_trig_n = 1, onchip_trig_n = 1;
    logic start_pulse, busy, pwr_on;

    int total = 0, bad = 0, npulse;
    bit finished = 0;

    // bench reference state
    logic [1:0] m_q1, m_q2;
    int         m_cnt [2];
    logic       m_busy, m_pulse, m_pwr;

    always #4 clk = ~clk;

    adc_trig_ctrl u_dut (
        .clk(clk), .rst(rst), .mode_cont(mode_cont), .ext_en(ext_en),
        .onchip_en(onchip_en), .sw_wr(sw_wr), .sw_start(sw_start),
        .pwr_wr(pwr_wr), .pwr_set(pwr_set), .halt_req(halt_req),
        .ext_trig_n(ext_trig_n), .onchip_trig_n(onchip_trig_n),
        .grp_done(grp_done), .start_pulse(start_pulse), .busy(busy),
        .pwr_on(pwr_on)
    );

    function automatic logic acc_of(logic q2, int cnt);
        return (q2 == 1'b0) && (cnt == 1);
    endfunction

    task automatic model_tick();
        logic a0, a1, trig, go;
        if (rst) begin
            m_q1 = 2'b11; m_q2 = 2'b11; m_cnt[0] = 0; m_cnt[1] = 0;
            m_busy = 0; m_pulse = 0; m_pwr = 0;
            return;
        end
        a0   = acc_of(m_q2[0], m_cnt[0]);
        a1   = acc_of(m_q2[1], m_cnt[1]);
        trig = (a0 & ext_en) | (a1 & onchip_en & m_pwr) | (sw_wr & sw_start & m_pwr);
        go   = !m_busy && trig;
        m_pulse = go;
        if (go) m_busy = 1;
        else if (m_busy && ((grp_done && !mode_cont) || (sw_wr && !sw_start))) m_busy = 0;
        if (halt_req) m_pwr = 0;
        else if (pwr_wr) m_pwr = pwr_set;
        for (int i = 0; i < 2; i++) begin
            if (m_q2[i]) m_cnt[i] = 0;
            else if (m_cnt[i] < 2) m_cnt[i] = m_cnt[i] + 1;
        end
        m_q2 = m_q1;
        m_q1 = {onchip_trig_n, ext_trig_n};
    endtask

    task automatic step();
        model_tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic steps(int n);
        for (int i = 0; i < n; i++) step();
    endtask

    task automatic chk(string req, string what, logic act, logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic count_pulses(int n);
        npulse = 0;
        for (int i = 0; i < n; i++) begin
            step();
            if (start_pulse) npulse++;
        end
    endtask

    initial begin
        #1_600_000;
        bad++;
        total++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        @(negedge clk);
        steps(3);
        rst = 0;
        // R1 reset state
        chk("R1", "busy", busy, 0);
        chk("R1", "start_pulse", start_pulse, 0);
        chk("R1", "pwr_on", pwr_on, 0);

        // R11 power write
        pwr_wr = 1; pwr_set = 1; step(); pwr_wr = 0;
        chk("R11", "pwr_on after write", pwr_on, 1);

        // R2 one-cycle glitch rejected
        ext_en = 1;
        ext_trig_n = 0; step(); ext_trig_n = 1;
        steps(5);
        chk("R2", "busy after glitch", busy, 0);

        // R2 valid low, fourth edge; R5 pulse
        ext_trig_n = 0;
        steps(3);
        chk("R2", "busy after third edge", busy, 0);
        step();
        chk("R2", "busy after fourth edge", busy, 1);
        chk("R5", "pulse with busy rise", start_pulse, 1);
        step();
        chk("R5", "pulse one cycle", start_pulse, 0);

        // R6 single-mode done; R3 held low does not restart
        grp_done = 1; step(); grp_done = 0;
        chk("R6", "busy after done", busy, 0);
        count_pulses(5);
        chk("R3", "no restart while held", (npulse == 0) && !busy, 1);
        ext_trig_n = 1; steps(3);

        // R10 software start, R8 trigger during busy ignored
        sw_wr = 1; sw_start = 1; step(); sw_wr = 0;
        chk("R10", "sw start busy", busy, 1);
        chk("R10", "sw start pulse", start_pulse, 1);
        ext_trig_n = 0;
        count_pulses(6);
        chk("R8", "no pulse while busy", npulse == 0, 1);
        ext_trig_n = 1; steps(3);
        grp_done = 1; step(); grp_done = 0;
        chk("R6", "busy cleared", busy, 0);

        // R4 disabled source
        ext_en = 0; ext_trig_n = 0;
        steps(6);
        chk("R4", "disabled ext", busy, 0);
        ext_trig_n = 1; ext_en = 1; steps(3);

        // R7 continuous mode
        mode_cont = 1; onchip_en = 1;
        sw_wr = 1; sw_start = 1; step(); sw_wr = 0;
        chk("R7", "cont start", busy, 1);
        grp_done = 1; step(); grp_done = 0;
        chk("R7", "done keeps busy", busy, 1);
        onchip_trig_n = 0;
        count_pulses(6);
        chk("R7", "no later pulse", npulse == 0, 1);
        onchip_trig_n = 1; steps(3);
        sw_wr = 1; sw_start = 0; step(); sw_wr = 0;
        chk("R10", "sw stop", busy, 0);
        mode_cont = 0;

        // R11 halt priority over write
        halt_req = 1; pwr_wr = 1; pwr_set = 1; step();
        halt_req = 0; pwr_wr = 0;
        chk("R11", "halt beats write", pwr_on, 0);

        // R9 power gating by source
        onchip_trig_n = 0; steps(6);
        chk("R9", "onchip unpowered", busy, 0);
        onchip_trig_n = 1; steps(3);
        sw_wr = 1; sw_start = 1; step(); sw_wr = 0;
        chk("R9", "sw unpowered", busy, 0);
        ext_trig_n = 0; steps(4);
        chk("R9", "ext unpowered", busy, 1);
        ext_trig_n = 1; steps(3);
        grp_done = 1; step(); grp_done = 0;

        // random phase against bench model
        void'($urandom(32'h5eed_1234));
        rst = 1; steps(2); rst = 0;
        for (int c = 0; c < 4000; c++) begin
            if ($urandom_range(5) == 0) ext_trig_n = ~ext_trig_n;
            if ($urandom_range(5) == 0) onchip_trig_n = ~onchip_trig_n;
            ext_en    = ($urandom_range(7) != 0);
            onchip_en = ($urandom_range(7) != 0);
            if ($urandom_range(63) == 0) mode_cont = ~mode_cont;
            sw_wr     = ($urandom_range(15) == 0);
            sw_start  = ($urandom_range(2) != 0);
            pwr_wr    = ($urandom_range(15) == 0);
            pwr_set   = ($urandom_range(4) != 0);
            halt_req  = ($urandom_range(47) == 0);
            grp_done  = ($urandom_range(7) == 0);
            step();
            chk("R5", "rand start_pulse", start_pulse, m_pulse);
            chk("R8", "rand busy", busy, m_busy);
            chk("R11", "rand pwr_on", pwr_on, m_pwr);
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule